// File: doc/BRIEF.md
# DVFS Controller Register Interface

This block is the register front end of a voltage and frequency scaling controller for several clock domains. It sits on a plain 32-bit register bus with an address, a write strobe with write data, and a read strobe with read data. Through that bus, software finds out whether scaling is enabled, how many domains exist, and which identifier each domain carries. For each domain it can also read a constant table of operating points, where each level index has a frequency and a voltage.

Access is indirect. Software writes a domain identifier into a select register. From then on, the level, acknowledge, level-count and table registers all refer to that domain. An entry-select register chooses which table row the frequency and voltage registers return. Writing a level index asks the selected domain to move to that level. The move completes after a programmable transition latency, and completion is signalled by a per-domain acknowledge flag that software polls.

Each domain keeps its own transition counter, so transitions in different domains overlap freely. Every read returns its data on the clock edge that samples the read strobe.

Top module: `dvfs_regif`

## Requirements
- R1: After reset:
  - status (0x00) reads 1;
  - domain select (0x10) reads 0xFFFFFFFF;
  - latency (0x0C) reads 6;
  - every domain is at level 0 with its acknowledge at 1.
- R2: Offset 0x04 reads the domain count (4, never above 32). Writing index i to 0x08 makes 0x08 read the identifier 0x10*(i+1). An index at or above the count reads 0.
- R3: Writing a listed identifier to 0x10 selects that domain, and 0x10 then reads it back. Any other identifier leaves no domain selected, and 0x10 reads 0xFFFFFFFF.
- R4: Offset 0x0C is read/write and keeps the low 16 bits of the written value.
- R5: A level write (0x14) below the selected domain's level count behaves as follows:
  - the acknowledge (0x18) reads 0 from the next read on;
  - with latency L, the acknowledge reads 1, and 0x14 returns the new level, from the read whose edge is L+2 edges after the write edge;
  - until then, 0x14 returns the old level.
- R6: Each domain has its own level and acknowledge. A transition in one domain does not change another domain's acknowledge or level. Offset 0x18 shows the selected domain's flag.
- R7: A level write with an index at or above the selected domain's level count is ignored. The level does not change, and the acknowledge keeps its value, even while a transition is running.
- R8: With no valid domain selected:
  - level writes are ignored;
  - 0x14, 0x18, 0x1C, 0x24 and 0x28 read 0.
- R9: Offset 0x1C reads 8 - (d mod 8) levels for the domain at index d.
- R10: After entry e is written to 0x20, 0x24 reads 100 + 50*e + 7*d and 0x28 reads 700 + 25*e for the selected domain d. When e is at or above the level count, both read 0.
- R11: A valid level write during a running transition restarts the countdown with the new target. The earlier target is never applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Byte address of the register |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; rdata updates on the sampling edge |
| rdata | output | 32 | Read data, held between reads |

## Verification
The level-change path is tried with four patterns:
- latency 0, where completion is a single edge;
- a mid-range latency, read back edge by edge, which separates an off-by-one countdown from a correct one;
- a second write landing inside a running transition, which tells a restart apart from completing the stale target;
- an out-of-range index during a transition, which shows whether a rejected write wrongly clears the flag.

Seeded random rounds pick domains, table entries (some beyond the level count), levels (some invalid) and latencies. These rounds check the table contents and level bookkeeping against bench formulas. An unlisted identifier followed by level writes shows that the invalid-selection path reads zero and changes nothing.

// File: rtl/dvfs_pkg.sv
// Package: register offsets and table formulas shared by the DVFS register block.
// Assumes byte addressing with word-aligned registers.
package dvfs_pkg;
    localparam logic [7:0] OFF_STATUS = 8'h00;
    localparam logic [7:0] OFF_NDOM   = 8'h04;
    localparam logic [7:0] OFF_IDAT   = 8'h08;
    localparam logic [7:0] OFF_LAT    = 8'h0C;
    localparam logic [7:0] OFF_SEL    = 8'h10;
    localparam logic [7:0] OFF_LVL    = 8'h14;
    localparam logic [7:0] OFF_ACK    = 8'h18;
    localparam logic [7:0] OFF_NLVL   = 8'h1C;
    localparam logic [7:0] OFF_ENTRY  = 8'h20;
    localparam logic [7:0] OFF_FREQ   = 8'h24;
    localparam logic [7:0] OFF_VOLT   = 8'h28;

    localparam int unsigned DOM_LIMIT = 32;

    // Identifier carried by the domain at a given index.
    function automatic logic [31:0] dom_id(input logic [31:0] idx,
                                           input logic [31:0] base,
                                           input logic [31:0] step);
        return base + idx * step;
    endfunction
endpackage

// File: rtl/dvfs_table_rom.sv
// Module: constant operating-point table. Returns the level count of a domain and,
// for one entry, its frequency and voltage. Entries outside the domain's range read 0.
// Assumes dom_idx addresses an existing domain when the caller uses the result.
module dvfs_table_rom #(
    parameter int unsigned N_DOM         = 4,
    parameter int unsigned MAX_LVL       = 8,
    parameter int unsigned FREQ_BASE     = 100,
    parameter int unsigned FREQ_STEP     = 50,
    parameter int unsigned FREQ_DOM_STEP = 7,
    parameter int unsigned VOLT_BASE     = 700,
    parameter int unsigned VOLT_STEP     = 25,
    localparam int unsigned DOM_W        = (N_DOM > 1) ? $clog2(N_DOM) : 1
) (
    input  logic [DOM_W-1:0] dom_idx,
    input  logic [31:0]      entry,
    output logic [31:0]      lvl_cnt,
    output logic [31:0]      freq,
    output logic [31:0]      volt
);
    logic [31:0] cnt_tab [N_DOM];

    // One level count per domain, shrinking with the index and never below one.
    for (genvar g = 0; g < N_DOM; g++) begin : g_cnt
        assign cnt_tab[g] = 32'(MAX_LVL - (g % MAX_LVL));
    end

    // Select the count of the addressed domain and derive the table row.
    always_comb begin
        lvl_cnt = 32'd0;
        if (32'(dom_idx) < 32'(N_DOM)) lvl_cnt = cnt_tab[dom_idx];
        if (entry < lvl_cnt) begin
            freq = 32'(FREQ_BASE) + entry * 32'(FREQ_STEP)
                 + 32'(dom_idx) * 32'(FREQ_DOM_STEP);
            volt = 32'(VOLT_BASE) + entry * 32'(VOLT_STEP);
        end else begin
            freq = 32'd0;
            volt = 32'd0;
        end
    end
endmodule

// File: rtl/dvfs_id_match.sv
// Module: maps a written domain identifier onto a domain index.
// Assumes identifiers are distinct; the lowest matching index wins.
module dvfs_id_match #(
    parameter int unsigned N_DOM   = 4,
    parameter logic [31:0] ID_BASE = 32'h10,
    parameter logic [31:0] ID_STEP = 32'h10,
    localparam int unsigned DOM_W  = (N_DOM > 1) ? $clog2(N_DOM) : 1
) (
    input  logic [31:0]      id,
    output logic             hit,
    output logic [DOM_W-1:0] idx
);
    logic [N_DOM-1:0] eq;

    // One comparator per domain.
    for (genvar g = 0; g < N_DOM; g++) begin : g_cmp
        assign eq[g] = (id == dvfs_pkg::dom_id(32'(g), ID_BASE, ID_STEP));
    end

    // Priority encode, scanning from the top so the lowest match is taken.
    always_comb begin
        hit = |eq;
        idx = '0;
        for (int i = N_DOM - 1; i >= 0; i--) begin
            if (eq[i]) idx = DOM_W'(i);
        end
    end
endmodule

// File: rtl/dvfs_domain_ctl.sv
// Module: transition engine of one domain. A request loads the countdown and clears
// the acknowledge. When the count is zero, the target becomes the current level and
// the acknowledge rises. Assumes the caller only requests valid levels.
module dvfs_domain_ctl #(
    parameter int unsigned LVL_W = 3,
    parameter int unsigned LAT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [LVL_W-1:0] req_lvl,
    input  logic [LAT_W-1:0] latency,
    output logic [LVL_W-1:0] cur_lvl,
    output logic             ack
);
    logic             busy;
    logic [LAT_W-1:0] cnt;
    logic [LVL_W-1:0] tgt;

    // Start or restart on a request; otherwise count down and complete at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cnt     <= '0;
            tgt     <= '0;
            cur_lvl <= '0;
            ack     <= 1'b1;
        end else if (req) begin
            busy <= 1'b1;
            cnt  <= latency;
            tgt  <= req_lvl;
            ack  <= 1'b0;
        end else if (busy) begin
            if (cnt == '0) begin
                cur_lvl <= tgt;
                ack     <= 1'b1;
                busy    <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/dvfs_regif.sv
// Module: top of the DVFS register interface. Decodes the register bus, holds the
// selector registers and the latency, and runs one transition engine per domain.
// Assumes single-cycle strobes and that wr_en and rd_en are not both high at once.
module dvfs_regif #(
    parameter int unsigned N_DOM         = 4,
    parameter int unsigned MAX_LVL       = 8,
    parameter int unsigned LAT_W         = 16,
    parameter int unsigned LAT_RST       = 6,
    parameter int unsigned HANDLER_ON    = 1,
    parameter logic [31:0] ID_BASE       = 32'h10,
    parameter logic [31:0] ID_STEP       = 32'h10,
    parameter int unsigned FREQ_BASE     = 100,
    parameter int unsigned FREQ_STEP     = 50,
    parameter int unsigned FREQ_DOM_STEP = 7,
    parameter int unsigned VOLT_BASE     = 700,
    parameter int unsigned VOLT_STEP     = 25,
    parameter int unsigned ADDR_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    input  logic              rd_en,
    output logic [31:0]       rdata
);
    import dvfs_pkg::*;

    localparam int unsigned DOM_W = (N_DOM > 1) ? $clog2(N_DOM) : 1;
    localparam int unsigned LVL_W = (MAX_LVL > 1) ? $clog2(MAX_LVL) : 1;

    logic [LAT_W-1:0]       lat_q;
    logic [31:0]            sel_id_q;
    logic                   sel_hit_q;
    logic [DOM_W-1:0]       sel_idx_q;
    logic [31:0]            idat_q;
    logic [31:0]            entry_q;
    logic                   m_hit;
    logic [DOM_W-1:0]       m_idx;
    logic [31:0]            sel_cnt;
    logic [31:0]            t_freq;
    logic [31:0]            t_volt;
    logic                   lvl_wr_ok;
    logic [N_DOM-1:0]       req_vec;
    logic [N_DOM-1:0]       ack_vec;
    logic [LVL_W-1:0]       lvl_arr [N_DOM];
    logic [N_DOM*LVL_W-1:0] lvl_pk;
    logic [31:0]            rd_mux;

    dvfs_id_match #(
        .N_DOM   (N_DOM),
        .ID_BASE (ID_BASE),
        .ID_STEP (ID_STEP)
    ) u_match (
        .id  (wdata),
        .hit (m_hit),
        .idx (m_idx)
    );

    dvfs_table_rom #(
        .N_DOM         (N_DOM),
        .MAX_LVL       (MAX_LVL),
        .FREQ_BASE     (FREQ_BASE),
        .FREQ_STEP     (FREQ_STEP),
        .FREQ_DOM_STEP (FREQ_DOM_STEP),
        .VOLT_BASE     (VOLT_BASE),
        .VOLT_STEP     (VOLT_STEP)
    ) u_rom (
        .dom_idx (sel_idx_q),
        .entry   (entry_q),
        .lvl_cnt (sel_cnt),
        .freq    (t_freq),
        .volt    (t_volt)
    );

    // Selector, index, entry and latency registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q     <= LAT_W'(LAT_RST);
            sel_id_q  <= '0;
            sel_hit_q <= 1'b0;
            sel_idx_q <= '0;
            idat_q    <= '0;
            entry_q   <= '0;
        end else if (wr_en) begin
            case (addr)
                ADDR_W'(OFF_LAT):   lat_q   <= wdata[LAT_W-1:0];
                ADDR_W'(OFF_IDAT):  idat_q  <= wdata;
                ADDR_W'(OFF_ENTRY): entry_q <= wdata;
                ADDR_W'(OFF_SEL): begin
                    sel_id_q  <= wdata;
                    sel_hit_q <= m_hit;
                    sel_idx_q <= m_idx;
                end
                default: ;
            endcase
        end
    end

    // A level write is accepted only for a valid domain and an in-range level.
    assign lvl_wr_ok = wr_en && (addr == ADDR_W'(OFF_LVL)) && sel_hit_q
                       && (wdata < sel_cnt);

    // One transition engine per domain.
    for (genvar g = 0; g < N_DOM; g++) begin : g_dom
        assign req_vec[g] = lvl_wr_ok && (sel_idx_q == DOM_W'(g));
        dvfs_domain_ctl #(
            .LVL_W (LVL_W),
            .LAT_W (LAT_W)
        ) u_ctl (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req_vec[g]),
            .req_lvl (wdata[LVL_W-1:0]),
            .latency (lat_q),
            .cur_lvl (lvl_arr[g]),
            .ack     (ack_vec[g])
        );
        assign lvl_pk[g*LVL_W +: LVL_W] = lvl_arr[g];
    end

    // Read multiplexer over all registers.
    always_comb begin
        rd_mux = 32'd0;
        case (addr)
            ADDR_W'(OFF_STATUS): rd_mux = (HANDLER_ON != 0) ? 32'd1 : 32'd0;
            ADDR_W'(OFF_NDOM):   rd_mux = 32'(N_DOM);
            ADDR_W'(OFF_IDAT):   rd_mux = (idat_q < 32'(N_DOM))
                                        ? dom_id(idat_q, ID_BASE, ID_STEP) : 32'd0;
            ADDR_W'(OFF_LAT):    rd_mux = 32'(lat_q);
            ADDR_W'(OFF_SEL):    rd_mux = sel_hit_q ? sel_id_q : 32'hFFFF_FFFF;
            ADDR_W'(OFF_LVL):    rd_mux = sel_hit_q ? 32'(lvl_arr[sel_idx_q]) : 32'd0;
            ADDR_W'(OFF_ACK):    rd_mux = sel_hit_q ? 32'(ack_vec[sel_idx_q]) : 32'd0;
            ADDR_W'(OFF_NLVL):   rd_mux = sel_hit_q ? sel_cnt : 32'd0;
            ADDR_W'(OFF_ENTRY):  rd_mux = entry_q;
            ADDR_W'(OFF_FREQ):   rd_mux = sel_hit_q ? t_freq : 32'd0;
            ADDR_W'(OFF_VOLT):   rd_mux = sel_hit_q ? t_volt : 32'd0;
            default:             rd_mux = 32'd0;
        endcase
    end

    // Read data register, loaded on a read strobe and held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end
endmodule

// File: rtl/dvfs_regif_chk.sv
// Module: property checker bound to dvfs_regif. Watches bus activity, the selection
// state and the per-domain engine outputs. Assumes the top's default register offsets.
module dvfs_regif_chk #(
    parameter int unsigned N_DOM      = 4,
    parameter int unsigned LVL_W      = 3,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned HANDLER_ON = 1,
    localparam int unsigned DOM_W     = (N_DOM > 1) ? $clog2(N_DOM) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      addr,
    input logic                   wr_en,
    input logic [31:0]            wdata,
    input logic                   rd_en,
    input logic [31:0]            rdata,
    input logic                   sel_hit,
    input logic [DOM_W-1:0]       sel_idx,
    input logic [31:0]            sel_cnt,
    input logic [N_DOM-1:0]       ack_vec,
    input logic [N_DOM*LVL_W-1:0] lvl_pk
);
    import dvfs_pkg::*;

    logic lvl_wr;
    logic lvl_bad;
    assign lvl_wr  = wr_en && (addr == ADDR_W'(OFF_LVL));
    assign lvl_bad = lvl_wr && (!sel_hit || (wdata >= sel_cnt));

    a_r1_status: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (addr == ADDR_W'(OFF_STATUS)) |=> rdata == ((HANDLER_ON != 0) ? 32'd1 : 32'd0));

    a_r2_dom_limit: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (addr == ADDR_W'(OFF_NDOM)) |=> (rdata != 32'd0) && (rdata <= 32'(DOM_LIMIT)));

    a_r8_invalid_lvl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (addr == ADDR_W'(OFF_LVL)) && !sel_hit |=> rdata == 32'd0);

    for (genvar g = 0; g < N_DOM; g++) begin : g_dom
        a_r5_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
            lvl_wr && !lvl_bad && (sel_idx == DOM_W'(g)) |=> !ack_vec[g]);

        a_r5_level_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(lvl_pk[g*LVL_W +: LVL_W]) |-> $rose(ack_vec[g]));

        a_r7_reject_keeps_ack: assert property (@(posedge clk) disable iff (!rst_n)
            lvl_bad |=> !$fell(ack_vec[g]));
    end
endmodule

bind dvfs_regif dvfs_regif_chk #(
    .N_DOM      (N_DOM),
    .LVL_W      (LVL_W),
    .ADDR_W     (ADDR_W),
    .HANDLER_ON (HANDLER_ON)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .rd_en   (rd_en),
    .rdata   (rdata),
    .sel_hit (sel_hit_q),
    .sel_idx (sel_idx_q),
    .sel_cnt (sel_cnt),
    .ack_vec (ack_vec),
    .lvl_pk  (lvl_pk)
);

// File: tb/sim_dvfs_regif.sv
// Bench: directed corner cases plus seeded random rounds, checked against formulas.
module sim_dvfs_regif;
    localparam logic [7:0] A_STAT = 8'h00, A_NDOM = 8'h04, A_IDAT = 8'h08,
                           A_LAT = 8'h0C, A_SEL = 8'h10, A_LVL = 8'h14,
                           A_ACK = 8'h18, A_NLVL = 8'h1C, A_ENT = 8'h20,
                           A_FRQ = 8'h24, A_VLT = 8'h28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] exp_lvl [4];

    always #4 clk = ~clk;

    dvfs_regif u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
                   .wdata(wdata), .rd_en(rd_en), .rdata(rdata));

    function automatic logic [31:0] f_id(input int i);   return 32'h10 * (i + 1); endfunction
    function automatic logic [31:0] f_cnt(input int d);  return 32'(8 - (d % 8)); endfunction
    function automatic logic [31:0] f_freq(input int d, input int e);
        return (32'(e) < f_cnt(d)) ? 32'(100 + 50 * e + 7 * d) : 32'd0;
    endfunction
    function automatic logic [31:0] f_volt(input int d, input int e);
        return (32'(e) < f_cnt(d)) ? 32'(700 + 25 * e) : 32'd0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write happens on the next posedge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic poll_ack(output int n);
        logic [31:0] v;
        n = 0;
        v = 0;
        while (v != 32'd1 && n < 40) begin
            rd(A_ACK, v);
            n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n;
        void'($urandom(32'd2024));
        for (int i = 0; i < 4; i++) exp_lvl[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_STAT, v); chk("R1 status", v, 32'd1);
        rd(A_SEL, v);  chk("R1 select", v, 32'hFFFF_FFFF);
        rd(A_LAT, v);  chk("R1 latency", v, 32'd6);
        for (int d = 0; d < 4; d++) begin
            wr(A_SEL, f_id(d));
            rd(A_LVL, v); chk("R1 level", v, 32'd0);
            rd(A_ACK, v); chk("R1 ack", v, 32'd1);
        end

        // R2 domain count and identifier list
        rd(A_NDOM, v); chk("R2 count", v, 32'd4);
        for (int i = 0; i <= 4; i++) begin
            wr(A_IDAT, 32'(i));
            rd(A_IDAT, v); chk("R2 id at index", v, (i < 4) ? f_id(i) : 32'd0);
        end

        // R3 select readback
        wr(A_SEL, 32'h30); rd(A_SEL, v); chk("R3 valid select", v, 32'h30);
        wr(A_SEL, 32'h31); rd(A_SEL, v); chk("R3 unknown select", v, 32'hFFFF_FFFF);

        // R4 latency width
        wr(A_LAT, 32'h0001_2345); rd(A_LAT, v); chk("R4 latency", v, 32'h2345);

        // R5 edge-exact completion with latency 3 on domain 1
        wr(A_LAT, 32'd3);
        wr(A_SEL, f_id(1));
        wr(A_LVL, 32'd5);
        for (int i = 1; i <= 5; i++) begin
            rd(A_ACK, v); chk("R5 ack timing", v, (i >= 5) ? 32'd1 : 32'd0);
        end
        rd(A_LVL, v); chk("R5 new level", v, 32'd5);
        exp_lvl[1] = 5;
        // R5 latency zero
        wr(A_LAT, 32'd0);
        wr(A_LVL, 32'd2);
        rd(A_ACK, v); chk("R5 ack zero latency first", v, 32'd0);
        rd(A_ACK, v); chk("R5 ack zero latency", v, 32'd1);
        rd(A_LVL, v); chk("R5 level zero latency", v, 32'd2);
        exp_lvl[1] = 2;

        // R6 independence: domain 0 busy, domain 1 unaffected
        wr(A_LAT, 32'd12);
        wr(A_SEL, f_id(0));
        wr(A_LVL, 32'd3);
        wr(A_SEL, f_id(1));
        rd(A_ACK, v); chk("R6 other ack", v, 32'd1);
        rd(A_LVL, v); chk("R6 other level", v, 32'd2);
        wr(A_SEL, f_id(0));
        rd(A_ACK, v); chk("R6 busy ack", v, 32'd0);
        rd(A_LVL, v); chk("R6 old level while busy", v, 32'd0);
        poll_ack(n);
        rd(A_LVL, v); chk("R6 level after", v, 32'd3);
        exp_lvl[0] = 3;

        // R7 out-of-range level, idle and during a transition
        wr(A_SEL, f_id(1));
        wr(A_LVL, 32'd7);
        rd(A_ACK, v); chk("R7 ack idle", v, 32'd1);
        rd(A_LVL, v); chk("R7 level idle", v, 32'd2);
        wr(A_LAT, 32'd8);
        wr(A_LVL, 32'd4);
        wr(A_LVL, 32'd9);
        rd(A_ACK, v); chk("R7 ack busy", v, 32'd0);
        poll_ack(n);
        rd(A_LVL, v); chk("R7 level busy", v, 32'd4);
        exp_lvl[1] = 4;

        // R11 restart with new target
        wr(A_LAT, 32'd4);
        wr(A_LVL, 32'd6);
        wr(A_LVL, 32'd1);
        for (int i = 1; i <= 6; i++) begin
            rd(A_ACK, v); chk("R11 restart ack", v, (i >= 6) ? 32'd1 : 32'd0);
        end
        rd(A_LVL, v); chk("R11 final level", v, 32'd1);
        exp_lvl[1] = 1;

        // R8 invalid selection
        wr(A_SEL, 32'h15);
        wr(A_LAT, 32'd0);
        wr(A_LVL, 32'd1);
        rd(A_LVL, v);  chk("R8 level", v, 32'd0);
        rd(A_ACK, v);  chk("R8 ack", v, 32'd0);
        rd(A_NLVL, v); chk("R8 count", v, 32'd0);
        wr(A_ENT, 32'd0);
        rd(A_FRQ, v);  chk("R8 freq", v, 32'd0);
        rd(A_VLT, v);  chk("R8 volt", v, 32'd0);
        for (int d = 0; d < 4; d++) begin
            wr(A_SEL, f_id(d));
            rd(A_LVL, v); chk("R8 untouched level", v, exp_lvl[d]);
        end

        // R10 boundary entry
        wr(A_SEL, f_id(3));
        wr(A_ENT, 32'd5);
        rd(A_FRQ, v); chk("R10 freq past end", v, 32'd0);
        wr(A_ENT, 32'd4);
        rd(A_FRQ, v); chk("R10 freq last", v, f_freq(3, 4));

        // R9 R10 R5 R7 random rounds
        for (int it = 0; it < 60; it++) begin
            int d, e, nl, lat;
            d = int'($urandom % 4);
            e = int'($urandom % 10);
            nl = int'($urandom % 10);
            lat = int'($urandom % 6);
            wr(A_SEL, f_id(d));
            wr(A_ENT, 32'(e));
            rd(A_NLVL, v); chk("R9 level count", v, f_cnt(d));
            rd(A_FRQ, v);  chk("R10 freq", v, f_freq(d, e));
            rd(A_VLT, v);  chk("R10 volt", v, f_volt(d, e));
            wr(A_LAT, 32'(lat));
            wr(A_LVL, 32'(nl));
            if (32'(nl) < f_cnt(d)) begin
                exp_lvl[d] = 32'(nl);
                poll_ack(n);
                chk("R5 random completion", 32'(n), 32'(lat + 2));
            end else begin
                rd(A_ACK, v); chk("R7 random reject ack", v, 32'd1);
            end
            rd(A_LVL, v); chk("R5 random level", v, exp_lvl[d]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule